// File: doc/BRIEF.md
# Two-Wire Bus Target with Clock Stretching

This block is the target (slave) side of an I2C bus. It samples SCL and SDA on the system clock and detects START, repeated START and STOP. After each START it reads the first byte as a 7-bit address plus a direction bit. It acknowledges that byte only when the address equals the programmed own address, or when the byte is a general call. During an access it moves data bytes between the bus and two one-byte holding registers, one for transmit and one for receive.

Software runs the data path through strobes. One strobe writes the transmit register, one reads the receive register, and one acknowledges the status flags. The status flags report access in progress, direction, transmit ready, receive ready, transfer complete, end of access, general call seen and clock wait. When software has not serviced a holding register in time, the block holds SCL low until it does. The bus master therefore never loses data and never sends a stale byte.

The pad drivers are open-drain. The block only states when each line must be pulled low, and the outputs named `*_drive_low` connect to the output-enable of a pad that drives 0.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset, all of the following hold. Access, receive ready, end of access, general call and clock wait are 0. Transmit ready and transfer complete are 1. Neither bus line is driven.
- R2: The first byte after a START holds the address in bits 7..1 and R/W in bit 0, where 1 means a read. When the address equals `own_addr`, the block pulls SDA low during the ninth clock, sets `acc_active`, and sets `dir_read` to the R/W bit.
- R3: When the address matches neither `own_addr` nor the general call, the block leaves SDA released in the ninth clock (a NACK). `acc_active` stays 0 and end of access is not raised.
- R4: In a write access, every byte is taken MSB first and acknowledged. It then appears on `rx_byte` with `rx_ready` set to 1.
- R5: A pulse on `rx_rd` clears `rx_ready`. If a new byte completes while `rx_ready` is still 1, the block does three things until `rx_rd` is pulsed: it holds SCL low, raises `clk_wait`, and leaves `rx_byte` unchanged. It then stores the new byte and releases SCL.
- R6: In a read access, bytes from the transmit register go out MSB first. `tx_ready` clears when software writes the register and when the byte moves into the shifter. It sets again on the SCL rise that samples the master's ACK or NACK.
- R7: If the transmit register is empty when a byte must be sent, the block holds SCL low and raises `clk_wait` until `tx_wr` is pulsed. It then sends that byte.
- R8: After the master NACKs a byte in a read access, the block leaves SDA released for all further clocks until a STOP or a START.
- R9: A STOP during an access clears `acc_active` and sets `xfer_done` and `end_of_access`. `end_of_access` and `gcall_seen` clear on a `status_rd` pulse.
- R10: A repeated START followed by `own_addr` keeps the access active and sets the direction anew. A repeated START followed by any other address ends the access, with the same flag effects as R9.
- R11: The general call byte 0x00 (address 0, write) is acknowledged and starts a write access with `gcall_seen` set to 1.
- R12: `xfer_done` clears when an address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (ACK or a data 0) |
| own_addr | input | 7 | Programmed target address |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_byte | input | 8 | Data for the transmit register |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_byte | output | 8 | Receive register contents |
| status_rd | input | 1 | Acknowledge strobe for the sticky flags |
| acc_active | output | 1 | An addressed access is in progress |
| dir_read | output | 1 | Access direction, 1 = master reads; valid only while `acc_active` is 1 |
| tx_ready | output | 1 | Transmit register may be written |
| rx_ready | output | 1 | Receive register holds an unread byte |
| xfer_done | output | 1 | No access in progress since the last one ended |
| end_of_access | output | 1 | Sticky: an access has ended |
| gcall_seen | output | 1 | Sticky: a general call was acknowledged |
| clk_wait | output | 1 | SCL is being held low by this block |

## Verification
The bench uses the default parameters: two synchronizer stages, a 7-bit address with an 8-bit data byte, and general call enabled. The bus clock phases are much longer than the synchronizer latency, so the exact edge timing inside the block never changes the result. The bench's bus model combines the master's lines with the block's open-drain pulls. This lets a stretched SCL stall the modelled master, so both stretch cases can be observed at the pins. Because the general call is enabled, the address-0 path and its sticky flag are also exercised.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_DEC,
    ST_ADDR_ACK,
    ST_RX_BIT,
    ST_RX_END,
    ST_RX_STORE,
    ST_RX_ACK,
    ST_TX_LOAD,
    ST_TX_BIT,
    ST_TX_ACK,
    ST_TX_NEXT,
    ST_SKIP
  } tgt_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
  import i2c_tgt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt,
  output logic     sda_lvl
);

  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    evt.start = scl_s & scl_p & sda_p & ~sda_s;
    evt.stop  = scl_s & scl_p & ~sda_p & sda_s;
    evt.rise  = scl_s & ~scl_p;
    evt.fall  = ~scl_s & scl_p;
  end

  assign sda_lvl = sda_s;

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_din,
  input  logic              tx_take,
  input  logic              tx_acked,
  output logic [DATA_W-1:0] thr_q,
  output logic              thr_full,
  output logic              tx_ready,
  input  logic              rx_put,
  input  logic [DATA_W-1:0] rx_din,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rhr_q,
  output logic              rx_full
);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q    <= '0;
      thr_full <= 1'b0;
      tx_ready <= 1'b1;
      rhr_q    <= '0;
      rx_full  <= 1'b0;
    end else begin
      if (tx_wr) begin
        thr_q    <= tx_din;
        thr_full <= 1'b1;
      end else if (tx_take) begin
        thr_full <= 1'b0;
      end

      if (tx_wr || tx_take) tx_ready <= 1'b0;
      else if (tx_acked)    tx_ready <= 1'b1;

      if (rx_put) begin
        rhr_q   <= rx_din;
        rx_full <= 1'b1;
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end
    end
  end

  // R6: moving a byte into the shifter drops transmit ready
  a_r6_take_clears_ready: assert property (@(posedge clk) disable iff (rst)
    tx_take |=> !tx_ready);

  // R5: the engine never stores over an unread byte
  a_r5_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    rx_put |-> (!rx_full || rx_rd));

  // R5: an unread byte stays put
  a_r5_hold_unread: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rx_rd && !rx_put) |=> $stable(rhr_q));

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter bit GCALL_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  input  logic              sda_lvl,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [DATA_W-1:0] thr_q,
  input  logic              thr_full,
  input  logic              rx_full,
  input  logic              rx_rd,
  input  logic              status_rd,
  output logic              tx_take,
  output logic              tx_acked,
  output logic              rx_put,
  output logic [DATA_W-1:0] rx_din,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              acc,
  output logic              dir_rd,
  output logic              xfer_done,
  output logic              end_acc,
  output logic              gcall
);

  localparam int LAST  = DATA_W - 1;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAST);

  tgt_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [LAST:0]    sh;
  logic             own_hit, gc_hit;

  assign own_hit  = (sh[LAST:1] == own_addr);
  assign gc_hit   = GCALL_EN && (sh[LAST:1] == '0) && !sh[0];
  assign tx_take  = (st == ST_TX_LOAD) && thr_full;
  assign rx_put   = (st == ST_RX_STORE) && (!rx_full || rx_rd);
  assign tx_acked = (st == ST_TX_ACK) && evt.rise && !evt.stop && !evt.start;
  assign rx_din   = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      acc       <= 1'b0;
      dir_rd    <= 1'b0;
      xfer_done <= 1'b1;
      end_acc   <= 1'b0;
      gcall     <= 1'b0;
    end else begin
      if (status_rd) begin
        end_acc <= 1'b0;
        gcall   <= 1'b0;
      end

      if (evt.stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
        if (acc) begin
          acc       <= 1'b0;
          xfer_done <= 1'b1;
          end_acc   <= 1'b1;
        end
      end else if (evt.start) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (evt.rise) begin
            sh <= {sh[LAST-1:0], sda_lvl};
            if (cnt == CNT_LAST) st <= ST_ADDR_DEC;
            else                 cnt <= cnt + 1'b1;
          end
          ST_ADDR_DEC: if (evt.fall) begin
            if (own_hit || gc_hit) begin
              sda_oe    <= 1'b1;
              acc       <= 1'b1;
              dir_rd    <= sh[0] && !gc_hit;
              xfer_done <= 1'b0;
              if (gc_hit) gcall <= 1'b1;
              st <= ST_ADDR_ACK;
            end else begin
              st <= ST_SKIP;
              if (acc) begin
                acc       <= 1'b0;
                xfer_done <= 1'b1;
                end_acc   <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: if (evt.fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= dir_rd ? ST_TX_LOAD : ST_RX_BIT;
          end
          ST_TX_LOAD: begin
            if (thr_full) begin
              sh     <= thr_q;
              sda_oe <= ~thr_q[LAST];
              scl_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_TX_BIT;
            end else begin
              scl_oe <= 1'b1;
            end
          end
          ST_TX_BIT: if (evt.fall) begin
            if (cnt == CNT_LAST) begin
              sda_oe <= 1'b0;
              st     <= ST_TX_ACK;
            end else begin
              sh     <= {sh[LAST-1:0], 1'b0};
              sda_oe <= ~sh[LAST-1];
              cnt    <= cnt + 1'b1;
            end
          end
          ST_TX_ACK: if (evt.rise) begin
            st <= sda_lvl ? ST_SKIP : ST_TX_NEXT;
          end
          ST_TX_NEXT: if (evt.fall) st <= ST_TX_LOAD;
          ST_RX_BIT: if (evt.rise) begin
            sh <= {sh[LAST-1:0], sda_lvl};
            if (cnt == CNT_LAST) st <= ST_RX_END;
            else                 cnt <= cnt + 1'b1;
          end
          ST_RX_END: if (evt.fall) st <= ST_RX_STORE;
          ST_RX_STORE: begin
            if (!rx_full || rx_rd) begin
              sda_oe <= 1'b1;
              scl_oe <= 1'b0;
              st     <= ST_RX_ACK;
            end else begin
              scl_oe <= 1'b1;
            end
          end
          ST_RX_ACK: if (evt.fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_RX_BIT;
          end
          ST_IDLE, ST_SKIP: ;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R2/R3: an access only opens after a matching or general-call address
  a_r3_access_needs_match: assert property (@(posedge clk) disable iff (rst)
    $rose(acc) |-> $past(own_hit || gc_hit));

  // R9: the end of an access leaves both completion flags raised
  a_r9_end_flags: assert property (@(posedge clk) disable iff (rst)
    $fell(acc) |-> (xfer_done && end_acc));

  // R1: no line is pulled while the bus is idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (!scl_oe && !sda_oe));

  // R8: after a master NACK or a foreign address, SDA is left alone
  a_r8_skip_release: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> !sda_oe);

  // R5/R7: SCL is held only while waiting on a holding register
  a_r7_stretch_reason: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> ((st == ST_TX_LOAD) || (st == ST_RX_STORE)));

endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter bit GCALL_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              tx_wr,
  input  logic [ADDR_W:0]   tx_byte,
  input  logic              rx_rd,
  output logic [ADDR_W:0]   rx_byte,
  input  logic              status_rd,
  output logic              acc_active,
  output logic              dir_read,
  output logic              tx_ready,
  output logic              rx_ready,
  output logic              xfer_done,
  output logic              end_of_access,
  output logic              gcall_seen,
  output logic              clk_wait
);

  localparam int DATA_W = ADDR_W + 1;

  logic [1:0]        lines_s;
  bus_evt_t          evt;
  logic              sda_lvl;
  logic [DATA_W-1:0] thr_q, rx_din;
  logic              thr_full, tx_take, tx_acked, rx_put, scl_oe;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (lines_s)
  );

  i2c_tgt_cond u_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (lines_s[1]),
    .sda_s   (lines_s[0]),
    .evt     (evt),
    .sda_lvl (sda_lvl)
  );

  i2c_tgt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .tx_wr    (tx_wr),
    .tx_din   (tx_byte),
    .tx_take  (tx_take),
    .tx_acked (tx_acked),
    .thr_q    (thr_q),
    .thr_full (thr_full),
    .tx_ready (tx_ready),
    .rx_put   (rx_put),
    .rx_din   (rx_din),
    .rx_rd    (rx_rd),
    .rhr_q    (rx_byte),
    .rx_full  (rx_ready)
  );

  i2c_tgt_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GCALL_EN(GCALL_EN)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .sda_lvl   (sda_lvl),
    .own_addr  (own_addr),
    .thr_q     (thr_q),
    .thr_full  (thr_full),
    .rx_full   (rx_ready),
    .rx_rd     (rx_rd),
    .status_rd (status_rd),
    .tx_take   (tx_take),
    .tx_acked  (tx_acked),
    .rx_put    (rx_put),
    .rx_din    (rx_din),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_drive_low),
    .acc       (acc_active),
    .dir_rd    (dir_read),
    .xfer_done (xfer_done),
    .end_acc   (end_of_access),
    .gcall     (gcall_seen)
  );

  assign scl_drive_low = scl_oe;
  assign clk_wait      = scl_oe;

endmodule

// File: tb/tb_i2c_target_stretch.sv
module tb_i2c_target_stretch;

  localparam int Q = 20;
  localparam int H = 40;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic tx_wr = 1'b0, rx_rd = 1'b0, status_rd = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic scl_drive_low, sda_drive_low;
  logic [7:0] rx_byte;
  logic acc_active, dir_read, tx_ready, rx_ready, xfer_done, end_of_access, gcall_seen, clk_wait;
  logic scl_bus, sda_bus;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign scl_bus = m_scl & ~scl_drive_low;
  assign sda_bus = m_sda & ~sda_drive_low;

  i2c_target_stretch dut (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .own_addr(OWN), .tx_wr(tx_wr), .tx_byte(tx_byte), .rx_rd(rx_rd),
    .rx_byte(rx_byte), .status_rd(status_rd), .acc_active(acc_active),
    .dir_read(dir_read), .tx_ready(tx_ready), .rx_ready(rx_ready),
    .xfer_done(xfer_done), .end_of_access(end_of_access),
    .gcall_seen(gcall_seen), .clk_wait(clk_wait)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    wclk(Q); m_sda = b; wclk(Q); scl_up(); wclk(H); m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wclk(Q); m_sda = 1'b1; wclk(Q); scl_up(); wclk(Q); b = sda_bus; wclk(Q); m_scl = 1'b0;
  endtask

  task automatic bus_start();
    wclk(Q); m_sda = 1'b1; wclk(Q); scl_up(); wclk(Q); m_sda = 1'b0; wclk(Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wclk(Q); m_sda = 1'b0; wclk(Q); scl_up(); wclk(Q); m_sda = 1'b1; wclk(H);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(ack);
  endtask

  task automatic rd_bits(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
  endtask

  task automatic pulse_rx_rd();
    @(negedge clk) rx_rd = 1'b1; @(negedge clk) rx_rd = 1'b0;
  endtask

  task automatic pulse_status();
    @(negedge clk) status_rd = 1'b1; @(negedge clk) status_rd = 1'b0;
  endtask

  task automatic put_tx(input logic [7:0] d);
    @(negedge clk) begin tx_byte = d; tx_wr = 1'b1; end
    @(negedge clk) tx_wr = 1'b0;
  endtask

  task automatic wait_stretch();
    while (!clk_wait) @(negedge clk);
    wclk(10);
  endtask

  task automatic t_reset();
    chk("R1 acc", acc_active, 0);   chk("R1 rx_ready", rx_ready, 0);
    chk("R1 eoa", end_of_access, 0); chk("R1 gcall", gcall_seen, 0);
    chk("R1 clk_wait", clk_wait, 0); chk("R1 tx_ready", tx_ready, 1);
    chk("R1 done", xfer_done, 1);
    chk("R1 lines", {scl_drive_low, sda_drive_low}, 0);
  endtask

  task automatic t_write();
    logic ack;
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    chk("R2 ack", ack, 0); chk("R2 acc", acc_active, 1); chk("R2 dir", dir_read, 0);
    chk("R12 done cleared", xfer_done, 0);
    write_byte(8'hA5, ack);
    chk("R4 data ack", ack, 0); chk("R4 rx_ready", rx_ready, 1); chk("R4 rx_byte", rx_byte, 8'hA5);
    pulse_rx_rd();
    chk("R5 rd clears", rx_ready, 0);
    bus_stop();
    chk("R9 acc fell", acc_active, 0); chk("R9 done", xfer_done, 1); chk("R9 eoa", end_of_access, 1);
    pulse_status();
    chk("R9 eoa cleared", end_of_access, 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    bus_start();
    write_byte({7'h21, 1'b0}, ack);
    chk("R3 nack", ack, 1); chk("R3 acc", acc_active, 0);
    bus_stop();
    chk("R3 no eoa", end_of_access, 0);
  endtask

  task automatic t_rx_stretch();
    logic ack, ack2;
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    write_byte(8'h3C, ack);
    fork
      write_byte(8'hC7, ack2);
      begin
        wait_stretch();
        chk("R5 scl held", scl_bus, 0); chk("R5 clk_wait", clk_wait, 1);
        chk("R5 old byte kept", rx_byte, 8'h3C);
        pulse_rx_rd();
      end
    join
    chk("R5 ack after read", ack2, 0); chk("R5 new byte", rx_byte, 8'hC7);
    chk("R5 released", clk_wait, 0); chk("R5 rx_ready", rx_ready, 1);
    pulse_rx_rd();
    bus_stop();
    pulse_status();
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] d, d2, d3;
    put_tx(8'hC3);
    chk("R6 write clears ready", tx_ready, 0);
    bus_start();
    write_byte({OWN, 1'b1}, ack);
    chk("R2 read ack", ack, 0); chk("R2 dir read", dir_read, 1);
    rd_bits(d);
    chk("R6 byte0", d, 8'hC3); chk("R6 ready low in flight", tx_ready, 0);
    bit_out(1'b0);
    chk("R6 ready after ack", tx_ready, 1);
    fork
      rd_bits(d2);
      begin
        wait_stretch();
        chk("R7 scl held", scl_bus, 0); chk("R7 clk_wait", clk_wait, 1);
        put_tx(8'h96);
      end
    join
    chk("R7 byte1", d2, 8'h96);
    bit_out(1'b1);
    chk("R6 ready after nack", tx_ready, 1);
    rd_bits(d3);
    chk("R8 released after nack", d3, 8'hFF);
    bus_stop();
    chk("R9 read end acc", acc_active, 0); chk("R9 read end eoa", end_of_access, 1);
    pulse_status();
  endtask

  task automatic t_gcall();
    logic ack;
    bus_start();
    write_byte(8'h00, ack);
    chk("R11 ack", ack, 0); chk("R11 gcall", gcall_seen, 1);
    chk("R11 acc", acc_active, 1); chk("R11 dir", dir_read, 0);
    write_byte(8'h11, ack);
    chk("R11 data", rx_byte, 8'h11);
    pulse_rx_rd();
    bus_stop();
    pulse_status();
    chk("R9 gcall cleared", gcall_seen, 0);
  endtask

  task automatic t_restart();
    logic ack;
    logic [7:0] d;
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    write_byte(8'h77, ack);
    chk("R4 byte before sr", rx_byte, 8'h77);
    pulse_rx_rd();
    put_tx(8'h5E);
    bus_start();
    write_byte({OWN, 1'b1}, ack);
    chk("R10 same addr ack", ack, 0); chk("R10 acc kept", acc_active, 1);
    chk("R10 dir updated", dir_read, 1); chk("R10 eoa not set", end_of_access, 0);
    rd_bits(d);
    chk("R10 byte", d, 8'h5E);
    bit_out(1'b1);
    bus_start();
    write_byte({7'h33, 1'b0}, ack);
    chk("R10 other nack", ack, 1); chk("R10 acc ended", acc_active, 0);
    chk("R10 eoa", end_of_access, 1); chk("R10 done", xfer_done, 1);
    bus_stop();
    pulse_status();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(5);
    t_reset();
    t_write();
    t_mismatch();
    t_rx_stretch();
    t_read();
    t_gcall();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule